// File: doc/BRIEF.md
# Rotation Turns Counter with Duty-Cycle Output

This block keeps a signed count of complete mechanical revolutions and reports it on one open-drain line as the duty cycle of a fixed-frequency pulse train. Two sign bits from the sine and cosine comparators give the rotation quadrant. A revolution is counted when the quadrant sequence passes the boundary between the fourth and the first quadrant. The count saturates at the ends of its signed range. A count of zero gives a 50% high time, and each turn moves the high time by one step of 1/2560 of the period, so the full range spans 10% to 90%.

The same line carries host commands, and the block tells them apart by how long the host holds the line low. A low of medium length starts counting and starts the pulse train. A long low also clears the count. Shorter lows are ignored. While the pulse train runs, the block compares the sampled line with its own delayed drive, so that only a low that outlasts its own pull-down can be read as a command. Once a command is accepted, the first falling edge of the pulse train follows the host's release after a fixed delay.

Top module: `turns_pwm_counter`

## Requirements
- R1: After reset `pd_o` is 0 and `count_o` is 0. Until the first accepted command, quadrant changes leave `count_o` at 0 and `pd_o` stays 0.
- R2: The quadrant index is {sin_neg_i, sin_neg_i ^ cos_neg_i} (Q1=0, Q2=1, Q3=2, Q4=3). Once counting is enabled, a step from index 3 to index 0 adds one to the count and a step from index 0 to index 3 subtracts one. The new value shows on `count_o` one clock after the inputs change.
- R3: Adjacent steps that do not cross the 3/0 boundary leave the count unchanged. A jump between diagonal quadrants (indices differing by 2) changes neither the count nor the tracked quadrant.
- R4: The count saturates at 2^(COUNT_W-1)-1 and at -2^(COUNT_W-1) and does not wrap.
- R5: A line low lasting fewer than START_CYC clock cycles is ignored.
- R6: A low lasting at least START_CYC but fewer than RESET_CYC cycles enables counting and restarts the pulse train, and it leaves the count unchanged.
- R7: A low lasting at least RESET_CYC cycles clears the count to 0 and restarts the pulse train.
- R8: After an accepted command, `pd_o` rises on the (START_DLY+4)th rising clock edge after the line returns high, and it stays 0 in between.
- R9: Each period lasts 2560·CLK_DIV cycles for COUNT_W=11 (in general 5·2^COUNT_W/4 ticks). It starts with `pd_o`=1 for (1280−C)·CLK_DIV cycles, followed by `pd_o`=0 for (1280+C)·CLK_DIV cycles, where C is the count at the start of the period.
- R10: A low caused by the block's own pull-down, including any host low that ends before the block releases the line, is not read as a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sin_neg_i | input | 1 | Sine comparator sign, 1 = negative |
| cos_neg_i | input | 1 | Cosine comparator sign, 1 = negative |
| pin_i | input | 1 | Sampled level of the shared open-drain line |
| pd_o | output | 1 | Pull-down enable for the shared line |
| count_o | output | COUNT_W | Signed turn count |

## Verification
The bench drives pulses of exactly START_CYC−1 and START_CYC cycles. A threshold that is off by one either starts the pulse train on the short pulse or misses the start. It steps the rotation through a diagonal jump and then returns to Q1. A tracker that followed the jump would lose the turn that follows, and the scoreboard is left holding that entry. It holds the line low inside the block's own low phase. A design without the drive comparison would restart there and distort that period. It also drives the count past both ends and measures the duty there, which exposes wrap-around and offset errors in the duty computation.

// File: rtl/tc_pkg.sv
package tc_pkg;

  typedef enum logic [1:0] {
    PWM_IDLE = 2'd0,
    PWM_WAIT = 2'd1,
    PWM_RUN  = 2'd2
  } pwm_state_e;

  // Q1=0 .. Q4=3 in rotation order
  function automatic logic [1:0] quad_idx(input logic sin_neg, input logic cos_neg);
    return {sin_neg, sin_neg ^ cos_neg};
  endfunction

endpackage

// File: rtl/tc_cmd_detect.sv
module tc_cmd_detect #(
  parameter int START_CYC = 31250,
  parameter int RESET_CYC = 275000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic drive_i,
  output logic start_o,
  output logic clear_o,
  output logic active_o
);

  localparam int RUN_W = $clog2(RESET_CYC + 1);
  localparam logic [RUN_W-1:0] START_LIM = RUN_W'(START_CYC);
  localparam logic [RUN_W-1:0] RESET_LIM = RUN_W'(RESET_CYC);

  logic s1_q, s2_q, s3_q;
  logic d1_q, d2_q;
  logic [RUN_W-1:0] run_q;
  logic ext_q, start_q, clear_q, active_q;
  logic rise;

  assign rise = s2_q & ~s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      s3_q <= 1'b1;
      d1_q <= 1'b0;
      d2_q <= 1'b0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
      // own drive delayed to line up with the synchroniser
      d1_q <= drive_i;
      d2_q <= d1_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      ext_q <= 1'b0;
    end else if (!s2_q) begin
      if (run_q != RESET_LIM) run_q <= run_q + 1'b1;
      if (!d2_q) ext_q <= 1'b1;
    end else begin
      run_q <= '0;
      ext_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q  <= 1'b0;
      clear_q  <= 1'b0;
      active_q <= 1'b0;
    end else begin
      start_q <= rise && ext_q && (run_q >= START_LIM);
      clear_q <= rise && ext_q && (run_q >= RESET_LIM);
      if (start_q) active_q <= 1'b1;
    end
  end

  assign start_o  = start_q;
  assign clear_o  = clear_q;
  assign active_o = active_q;

  p_clear_is_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_q |-> start_q);
  p_active_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(active_q) |-> active_q);
  p_short_low_ignored_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |-> ($past(run_q) >= START_LIM));

endmodule

// File: rtl/tc_turn_count.sv
module tc_turn_count
  import tc_pkg::*;
#(
  parameter int COUNT_W = 11
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      en_i,
  input  logic                      clr_i,
  input  logic                      sin_neg_i,
  input  logic                      cos_neg_i,
  output logic signed [COUNT_W-1:0] count_o
);

  localparam logic signed [COUNT_W-1:0] CMAX = {1'b0, {(COUNT_W-1){1'b1}}};
  localparam logic signed [COUNT_W-1:0] CMIN = {1'b1, {(COUNT_W-1){1'b0}}};
  localparam logic signed [COUNT_W-1:0] ONE  = COUNT_W'(1);

  logic [1:0] q_cur, prev_q;
  logic fwd, bwd, diag;
  logic signed [COUNT_W-1:0] count_q;

  assign q_cur = quad_idx(sin_neg_i, cos_neg_i);
  assign diag  = (q_cur ^ prev_q) == 2'b10;
  assign fwd   = (prev_q == 2'd3) && (q_cur == 2'd0);
  assign bwd   = (prev_q == 2'd0) && (q_cur == 2'd3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                prev_q <= 2'd0;
    else if (!en_i || !diag)    prev_q <= q_cur;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                count_q <= '0;
    else if (clr_i)                             count_q <= '0;
    else if (en_i && fwd && count_q != CMAX)    count_q <= count_q + ONE;
    else if (en_i && bwd && count_q != CMIN)    count_q <= count_q - ONE;
  end

  assign count_o = count_q;

  p_unit_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(clr_i) && count_q != $past(count_q)) |->
      (count_q == $past(count_q) + ONE || count_q == $past(count_q) - ONE));
  p_no_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(clr_i) && $past(count_q) == CMAX) |-> count_q != CMIN);
  p_no_wrap_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(clr_i) && $past(count_q) == CMIN) |-> count_q != CMAX);
  p_idle_frozen_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(en_i) && !$past(clr_i)) |-> $stable(count_q));
  p_diag_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && diag) |=> $stable(prev_q));

endmodule

// File: rtl/tc_pwm_gen.sv
module tc_pwm_gen
  import tc_pkg::*;
#(
  parameter int COUNT_W   = 11,
  parameter int CLK_DIV   = 39,
  parameter int START_DLY = 13750
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic signed [COUNT_W-1:0] count_i,
  output logic                      pd_o
);

  localparam int STEPS = 2 ** COUNT_W;
  localparam int PT    = STEPS + STEPS / 4;
  localparam int MID   = PT / 2;
  localparam int PH_W  = $clog2(PT);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int DLY_W = $clog2(START_DLY + 1);

  localparam logic [PH_W-1:0]  PT_V     = PH_W'(PT);
  localparam logic [PH_W-1:0]  PT_LAST  = PH_W'(PT - 1);
  localparam logic [PH_W-1:0]  MID_V    = PH_W'(MID);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
  localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(START_DLY - 1);

  pwm_state_e state_q, state_n;
  logic [PH_W-1:0]  phase_q, phase_n, hi_q, hi_n, hi_calc;
  logic [DIV_W-1:0] div_q, div_n;
  logic [DLY_W-1:0] wcnt_q, wcnt_n;
  logic pd_q, pd_n, tick;
  logic signed [PH_W:0] hi_sum;

  // released time = MID + count ticks
  assign hi_sum  = $signed({1'b0, MID_V}) + (PH_W+1)'(count_i);
  assign hi_calc = hi_sum[PH_W-1:0];
  assign tick    = div_q == DIV_LAST;

  always_comb begin
    state_n = state_q;
    phase_n = phase_q;
    div_n   = div_q;
    hi_n    = hi_q;
    wcnt_n  = wcnt_q;
    unique case (state_q)
      PWM_WAIT: begin
        if (wcnt_q == DLY_LAST) begin
          state_n = PWM_RUN;
          phase_n = '0;
          div_n   = '0;
          hi_n    = hi_calc;
        end else begin
          wcnt_n = wcnt_q + 1'b1;
        end
      end
      PWM_RUN: begin
        if (tick) begin
          div_n = '0;
          if (phase_q == PT_LAST) begin
            phase_n = '0;
            hi_n    = hi_calc;
          end else begin
            phase_n = phase_q + 1'b1;
          end
        end else begin
          div_n = div_q + 1'b1;
        end
      end
      default: ;
    endcase
    if (start_i) begin
      state_n = PWM_WAIT;
      wcnt_n  = '0;
    end
    pd_n = (state_n == PWM_RUN) && (phase_n < (PT_V - hi_n));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PWM_IDLE;
      phase_q <= '0;
      div_q   <= '0;
      hi_q    <= MID_V;
      wcnt_q  <= '0;
      pd_q    <= 1'b0;
    end else begin
      state_q <= state_n;
      phase_q <= phase_n;
      div_q   <= div_n;
      hi_q    <= hi_n;
      wcnt_q  <= wcnt_n;
      pd_q    <= pd_n;
    end
  end

  assign pd_o = pd_q;

  p_idle_released_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PWM_IDLE) |-> !pd_q);
  p_wait_released_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PWM_WAIT) |-> !pd_q);
  p_first_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PWM_RUN && $past(state_q) == PWM_WAIT) |-> pd_q);
  p_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (state_q == PWM_WAIT));

endmodule

// File: rtl/turns_pwm_counter.sv
module turns_pwm_counter #(
  parameter int COUNT_W   = 11,
  parameter int CLK_DIV   = 39,
  parameter int START_CYC = 31250,
  parameter int RESET_CYC = 275000,
  parameter int START_DLY = 13750
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      sin_neg_i,
  input  logic                      cos_neg_i,
  input  logic                      pin_i,
  output logic                      pd_o,
  output logic signed [COUNT_W-1:0] count_o
);

  logic start, clear, active, pd;
  logic signed [COUNT_W-1:0] count;

  tc_cmd_detect #(
    .START_CYC (START_CYC),
    .RESET_CYC (RESET_CYC)
  ) i_cmd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pin_i    (pin_i),
    .drive_i  (pd),
    .start_o  (start),
    .clear_o  (clear),
    .active_o (active)
  );

  tc_turn_count #(
    .COUNT_W (COUNT_W)
  ) i_count (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (active),
    .clr_i     (clear),
    .sin_neg_i (sin_neg_i),
    .cos_neg_i (cos_neg_i),
    .count_o   (count)
  );

  tc_pwm_gen #(
    .COUNT_W   (COUNT_W),
    .CLK_DIV   (CLK_DIV),
    .START_DLY (START_DLY)
  ) i_pwm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .count_i (count),
    .pd_o    (pd)
  );

  assign pd_o    = pd;
  assign count_o = count;

endmodule

// File: tb/test_turns_pwm_counter.sv
`timescale 1ns/1ps
module test_turns_pwm_counter;

  localparam int W   = 11;
  localparam int DIV = 2;
  localparam int SC  = 20;
  localparam int RC  = 60;
  localparam int DLY = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sin_neg = 1'b0, cos_neg = 1'b0;
  logic host_low = 1'b0;
  logic pin, pd;
  logic signed [W-1:0] count;

  int n_chk = 0, n_err = 0;
  int exp_q[$];
  int exp_cnt = 0;
  int tr_q = 0;
  bit active = 1'b0;
  int last_cnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  assign pin = !(pd || host_low);

  turns_pwm_counter #(
    .COUNT_W(W), .CLK_DIV(DIV), .START_CYC(SC), .RESET_CYC(RC), .START_DLY(DLY)
  ) i_turns_pwm_counter (
    .clk_i(clk), .rst_ni(rst_n), .sin_neg_i(sin_neg), .cos_neg_i(cos_neg),
    .pin_i(pin), .pd_o(pd), .count_o(count)
  );

  function automatic void chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endfunction

  function automatic void push(int v);
    exp_q.push_back(v);
    exp_cnt = v;
  endfunction

  // monitor: every change of the count must match the next expected item
  always @(negedge clk) begin
    if (rst_n && int'(count) != last_cnt) begin
      if (exp_q.size() == 0) chk(1'b0, "R2/R4/R7 unexpected count change", int'(count), last_cnt);
      else chk(int'(count) == exp_q.pop_front(), "R2/R4/R7 scoreboard", int'(count), exp_cnt);
      last_cnt = int'(count);
    end
  end

  task automatic step_to(int q);
    if (active) begin
      if ((q ^ tr_q) != 2) begin
        if (tr_q == 3 && q == 0 && exp_cnt < 1023)  push(exp_cnt + 1);
        if (tr_q == 0 && q == 3 && exp_cnt > -1024) push(exp_cnt - 1);
        tr_q = q;
      end
    end else tr_q = q;
    @(negedge clk);
    sin_neg = q[1];
    cos_neg = q[1] ^ q[0];
    @(negedge clk);
  endtask

  task automatic turn(int dir);
    for (int i = 0; i < 4; i++) step_to(dir > 0 ? (tr_q + 1) % 4 : (tr_q + 3) % 4);
  endtask

  task automatic low_pulse(int len);
    host_low = 1'b1;
    repeat (len) @(negedge clk);
    host_low = 1'b0;
  endtask

  task automatic cmd_latency(int len, string req);
    int n;
    low_pulse(len);
    n = 0;
    do begin @(negedge clk); n++; end while (!pd && n < 500);
    chk(n == DLY + 4, req, n, DLY + 4);
  endtask

  task automatic wait_fall();
    while (!pd) @(negedge clk);
    while (pd) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic measure(int c, string req);
    int h, l;
    while (pd) @(negedge clk);
    while (!pd) @(negedge clk);
    h = 0;
    while (pd) begin h++; @(negedge clk); end
    l = 0;
    while (!pd) begin l++; @(negedge clk); end
    chk(h == (1280 - c) * DIV, {req, " pull-down time"}, h, (1280 - c) * DIV);
    chk(l == (1280 + c) * DIV, {req, " release time"}, l, (1280 + c) * DIV);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int seen, h;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pd == 1'b0, "R1 reset pd", pd, 0);
    chk(count == 0, "R1 reset count", int'(count), 0);

    turn(1); turn(1);
    chk(count == 0, "R1 idle turns", int'(count), 0);
    chk(pd == 1'b0, "R1 idle pd", pd, 0);

    low_pulse(SC - 1);
    seen = 0;
    repeat (60) begin @(negedge clk); if (pd) seen++; end
    chk(seen == 0, "R5 short pulse", seen, 0);
    turn(1);
    chk(count == 0, "R5 still idle", int'(count), 0);

    cmd_latency(SC, "R8 first edge latency (R6 start)");
    active = 1'b1;
    measure(0, "R9 zero count");

    turn(1); turn(1); turn(1); turn(-1);
    chk(count == 2, "R2 net turns", int'(count), 2);

    step_to(1); step_to(0);
    chk(count == 2, "R3 adjacent back", int'(count), 2);
    step_to(1); step_to(2); step_to(3);
    chk(count == 2, "R3 adjacent forward", int'(count), 2);
    step_to(1);
    chk(count == 2, "R3 diagonal jump", int'(count), 2);
    step_to(0);
    chk(count == 3, "R3 tracked quadrant kept", int'(count), 3);

    measure(3, "R9 count 3");

    // R10: host low inside own pull-down phase
    while (pd) @(negedge clk);
    while (!pd) @(negedge clk);
    h = 0;
    host_low = 1'b1;
    repeat (100) begin h++; @(negedge clk); end
    host_low = 1'b0;
    while (pd) begin h++; @(negedge clk); end
    chk(h == (1280 - 3) * DIV, "R10 own drive masked", h, (1280 - 3) * DIV);

    wait_fall();
    cmd_latency(SC + 5, "R8 restart latency");
    chk(count == 3, "R6 count kept", int'(count), 3);

    wait_fall();
    push(0);
    low_pulse(RC);
    repeat (20) @(negedge clk);
    chk(count == 0, "R7 clear", int'(count), 0);
    measure(0, "R9 after clear");

    for (int i = 0; i < 1030; i++) turn(1);
    chk(count == 1023, "R4 upper limit", int'(count), 1023);
    measure(1023, "R9 upper");

    wait_fall();
    push(0);
    low_pulse(RC);
    repeat (20) @(negedge clk);
    chk(count == 0, "R7 clear again", int'(count), 0);
    for (int i = 0; i < 1030; i++) turn(-1);
    chk(count == -1024, "R4 lower limit", int'(count), -1024);
    measure(-1024, "R9 lower");

    chk(exp_q.size() == 0, "R2 R3 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule